// File: doc/BRIEF.md
# Self-Reloading Countdown Timer with Pulsed Interrupt

This block is an 8-bit down counter that restarts itself. Software writes a start value. Software also writes a control byte that turns counting on and chooses one of four rates: 4096 Hz, 64 Hz, 1 Hz or one tick per minute. The rates arrive as single-cycle enable strobes from a prescaler outside the block, so the whole design runs on one system clock. Each strobe of the chosen rate moves the count down by one. When the count passes through 1, the counter reloads the start value, sets a sticky timer flag and launches an interrupt pulse. The pulse width depends on the rate and on whether the start value is exactly 1.

The pulse width is timed with a separate 8192 Hz reference strobe. If software turns counting off, any pulse in progress is cut short. The current count can be read back at any time. The flag is cleared with an AND-type write: a 0 clears the flag, and a 1 leaves it as it is. A start value of zero parks the timer.

Top module: `cdt_timer`

## Requirements
- R1: The control register reads back as enable in bit 7, the rate select in bits 1:0 and zeros in bits 6:2. The select codes are 00 = 4096 Hz strobe, 01 = 64 Hz strobe, 10 = 1 Hz strobe and 11 = 1/60 Hz strobe.
- R2: After reset the control register reads 8'h03 (disabled, 1/60 Hz), and the count, timer flag and pulse are all 0.
- R3: While enabled with a nonzero start value n, each cycle that carries the selected strobe lowers the count by one. A strobe taken at count 1 reloads n, so the value read back is always the live count.
- R4: A start value of 0 halts the timer: the count stays 0 and neither the flag nor the pulse is raised.
- R5: On the clock edge that takes a strobe at count 1, the timer flag and the interrupt pulse both go high.
- R6: A flag write with keep = 0 clears the flag, and keep = 1 leaves it unchanged. A countdown end in the same cycle as a clearing write leaves the flag set.
- R7: The pulse stays high until the edge that takes its N-th reference strobe. N is 1 (n = 1) or 2 (n > 1) at 4096 Hz, 64 (n = 1) or 128 (n > 1) at 64 Hz, and 128 at 1 Hz and 1/60 Hz.
- R8: A start-value write loads the live count on the same edge and takes priority over a rate strobe in that cycle.
- R9: While disabled the count holds, and a pulse in progress is cleared on the edge after the enable bit reads 0.
- R10: Strobes of rates other than the selected one leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_4096_stb | input | 1 | 4096 Hz enable strobe |
| rate_64_stb | input | 1 | 64 Hz enable strobe |
| rate_1_stb | input | 1 | 1 Hz enable strobe |
| rate_sixtieth_stb | input | 1 | One-per-minute enable strobe |
| ref_8192_stb | input | 1 | 8192 Hz reference strobe for pulse width |
| ctl_wr | input | 1 | Control register write |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| val_wr | input | 1 | Start value write, also loads the count |
| val_wdata | input | 8 | Start value write data |
| val_rdata | output | 8 | Live count |
| flag_wr | input | 1 | Timer flag AND-write strobe |
| flag_keep | input | 1 | Flag write data: 0 clears, 1 keeps |
| timer_flag | output | 1 | Sticky timer flag |
| irq_pulse | output | 1 | Interrupt pulse |

## Verification
The hardest cases to reach are the ones where two things happen on the same edge. One is a countdown end that meets a clearing flag write. Another is a start-value write that lands on a rate strobe. A third is turning the timer off part-way through a 128-strobe pulse. Directed sequences build each of these cases on purpose. The bench times the strobes so that the count reaches 1 in the chosen cycle, and it counts the reference strobes seen while the pulse is high to confirm every width case. A long run with a fixed seed then mixes random strobes, writes and small start values. A cycle model in the bench predicts all four outputs on every clock.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  typedef enum logic [1:0] {
    SRC_4096  = 2'b00,
    SRC_64    = 2'b01,
    SRC_1     = 2'b10,
    SRC_60TH  = 2'b11
  } src_sel_e;

  localparam int NUM_RATES = 4;
endpackage

// File: rtl/cdt_ctrl_reg.sv
`timescale 1ns/1ps
module cdt_ctrl_reg
  import cdt_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             en,
  output src_sel_e         sel,
  output logic [REG_W-1:0] rdata
);
  logic unused_mid_bits;
  assign unused_mid_bits = ^wdata[REG_W-2:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      sel <= SRC_60TH;
    end else if (wr) begin
      en  <= wdata[REG_W-1];
      sel <= src_sel_e'(wdata[1:0]);
    end
  end

  always_comb begin
    rdata          = '0;
    rdata[REG_W-1] = en;
    rdata[1:0]     = sel;
  end
endmodule

// File: rtl/cdt_rate_select.sv
`timescale 1ns/1ps
module cdt_rate_select
  import cdt_pkg::*;
(
  input  logic [NUM_RATES-1:0] rate_stb,
  input  src_sel_e             sel,
  output logic                 sel_stb
);
  logic [NUM_RATES-1:0] hit;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_hit
    assign hit[g] = rate_stb[g] && (sel == src_sel_e'(g));
  end

  assign sel_stb = |hit;
endmodule

// File: rtl/cdt_down_counter.sv
`timescale 1ns/1ps
module cdt_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         stb,
  input  logic         ld_wr,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] cnt,
  output logic [W-1:0] load,
  output logic         done,
  output logic         load_one
);
  logic tick;

  assign tick     = run && stb && (load != '0);
  assign done     = tick && (cnt == W'(1)) && !ld_wr;
  assign load_one = (load == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      load <= '0;
    end else if (ld_wr) begin
      load <= ld_data;
      cnt  <= ld_data;
    end else if (tick) begin
      if (cnt <= W'(1)) cnt <= load;
      else              cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/cdt_pulse_shaper.sv
`timescale 1ns/1ps
module cdt_pulse_shaper
  import cdt_pkg::*;
#(
  parameter int PW_W        = 8,
  parameter int PW_FAST_ONE = 1,
  parameter int PW_FAST     = 2,
  parameter int PW_MID_ONE  = 64,
  parameter int PW_MID      = 128,
  parameter int PW_SLOW     = 128
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     done,
  input  src_sel_e sel,
  input  logic     load_one,
  input  logic     ref_stb,
  output logic     pulse
);
  logic [PW_W-1:0] width;
  logic [PW_W-1:0] rem;

  always_comb begin
    case (sel)
      SRC_4096: width = load_one ? PW_W'(PW_FAST_ONE) : PW_W'(PW_FAST);
      SRC_64:   width = load_one ? PW_W'(PW_MID_ONE)  : PW_W'(PW_MID);
      default:  width = PW_W'(PW_SLOW);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pulse <= 1'b0;
      rem   <= '0;
    end else if (done) begin
      pulse <= 1'b1;
      rem   <= width;
    end else if (pulse && ref_stb) begin
      if (rem <= PW_W'(1)) begin
        pulse <= 1'b0;
        rem   <= '0;
      end else begin
        rem <= rem - PW_W'(1);
      end
    end
  end
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PW_FAST_ONE = 1,
  parameter int PW_FAST     = 2,
  parameter int PW_MID_ONE  = 64,
  parameter int PW_MID      = 128,
  parameter int PW_SLOW     = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_4096_stb,
  input  logic             rate_64_stb,
  input  logic             rate_1_stb,
  input  logic             rate_sixtieth_stb,
  input  logic             ref_8192_stb,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  output logic [CNT_W-1:0] val_rdata,
  input  logic             flag_wr,
  input  logic             flag_keep,
  output logic             timer_flag,
  output logic             irq_pulse
);
  localparam int PW_MAX_A = (PW_FAST > PW_FAST_ONE) ? PW_FAST : PW_FAST_ONE;
  localparam int PW_MAX_B = (PW_MID > PW_MID_ONE) ? PW_MID : PW_MID_ONE;
  localparam int PW_MAX_C = (PW_MAX_A > PW_MAX_B) ? PW_MAX_A : PW_MAX_B;
  localparam int PW_MAX   = (PW_MAX_C > PW_SLOW) ? PW_MAX_C : PW_SLOW;
  localparam int PW_W     = $clog2(PW_MAX + 1);

  logic                 en_q;
  src_sel_e             sel_q;
  logic [NUM_RATES-1:0] rate_vec;
  logic                 sel_stb;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     load_q;
  logic                 done;
  logic                 load_one;

  assign rate_vec = {rate_sixtieth_stb, rate_1_stb, rate_64_stb, rate_4096_stb};

  cdt_ctrl_reg #(.REG_W(8)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .en    (en_q),
    .sel   (sel_q),
    .rdata (ctl_rdata)
  );

  cdt_rate_select u_rsel (
    .rate_stb (rate_vec),
    .sel      (sel_q),
    .sel_stb  (sel_stb)
  );

  cdt_down_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (en_q),
    .stb      (sel_stb),
    .ld_wr    (val_wr),
    .ld_data  (val_wdata),
    .cnt      (cnt_q),
    .load     (load_q),
    .done     (done),
    .load_one (load_one)
  );

  cdt_pulse_shaper #(
    .PW_W        (PW_W),
    .PW_FAST_ONE (PW_FAST_ONE),
    .PW_FAST     (PW_FAST),
    .PW_MID_ONE  (PW_MID_ONE),
    .PW_MID      (PW_MID),
    .PW_SLOW     (PW_SLOW)
  ) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .done     (done),
    .sel      (sel_q),
    .load_one (load_one),
    .ref_stb  (ref_8192_stb),
    .pulse    (irq_pulse)
  );

  // Sticky flag: AND-type clear, a countdown end wins over a clear.
  always_ff @(posedge clk) begin
    if (rst) timer_flag <= 1'b0;
    else     timer_flag <= (timer_flag && (!flag_wr || flag_keep)) || done;
  end

  assign val_rdata = cnt_q;
endmodule

// File: rtl/cdt_timer_chk.sv
`timescale 1ns/1ps
module cdt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic [1:0]       sel_q,
  input logic             rate_4096_stb,
  input logic             val_wr,
  input logic             flag_wr,
  input logic             done,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic             timer_flag,
  input logic             irq_pulse
);
  // R3: a running count stays within 1..start value
  p_count_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    (load_q != '0) |-> (cnt_q != '0 && cnt_q <= load_q));

  // R4: a zero start value keeps the count parked
  p_zero_halts_r4: assert property (@(posedge clk) disable iff (rst)
    (load_q == '0 && !val_wr) |=> (cnt_q == '0 && !done));

  // R5: flag and pulse rise together
  p_flag_with_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> (timer_flag && irq_pulse));

  p_pulse_rise_flag_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pulse) |-> timer_flag);

  // R6: flag only drops through a software write
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (timer_flag && !flag_wr) |=> timer_flag);

  // R9: disabled timer ends the pulse and freezes the count
  p_disable_ends_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq_pulse);

  p_disable_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !val_wr) |=> $stable(cnt_q));

  // R10: with the 4096 Hz rate selected and no such strobe, count holds
  p_unselected_r10: assert property (@(posedge clk) disable iff (rst)
    (sel_q == 2'b00 && !rate_4096_stb && !val_wr) |=> $stable(cnt_q));
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .en_q          (en_q),
  .sel_q         (sel_q),
  .rate_4096_stb (rate_4096_stb),
  .val_wr        (val_wr),
  .flag_wr       (flag_wr),
  .done          (done),
  .cnt_q         (cnt_q),
  .load_q        (load_q),
  .timer_flag    (timer_flag),
  .irq_pulse     (irq_pulse)
);

// File: tb/sim_cdt_timer.sv
`timescale 1ns/1ps
module sim_cdt_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       r4096 = 0, r64 = 0, r1 = 0, r60 = 0, ref_stb = 0;
  logic       ctl_wr = 0;
  logic [7:0] ctl_wdata = 0;
  logic [7:0] ctl_rdata;
  logic       val_wr = 0;
  logic [7:0] val_wdata = 0;
  logic [7:0] val_rdata;
  logic       flag_wr = 0, flag_keep = 0;
  logic       timer_flag, irq_pulse;

  int checks = 0;
  int failures = 0;
  int cyc_n = 0;
  int pw_seen = 0;
  bit auto_ref = 0;
  bit finished = 0;

  // bench model state
  logic       m_en, m_flag, m_pulse;
  logic [1:0] m_sel;
  logic [7:0] m_load, m_cnt;
  int         m_rem;

  always #2 clk = ~clk;

  cdt_timer u0 (
    .clk (clk), .rst (rst),
    .rate_4096_stb (r4096), .rate_64_stb (r64), .rate_1_stb (r1),
    .rate_sixtieth_stb (r60), .ref_8192_stb (ref_stb),
    .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata), .ctl_rdata (ctl_rdata),
    .val_wr (val_wr), .val_wdata (val_wdata), .val_rdata (val_rdata),
    .flag_wr (flag_wr), .flag_keep (flag_keep),
    .timer_flag (timer_flag), .irq_pulse (irq_pulse)
  );

  function automatic int exp_width(logic [1:0] sel, bit one);
    case (sel)
      2'b00:   return one ? 1 : 2;
      2'b01:   return one ? 64 : 128;
      default: return 128;
    endcase
  endfunction

  function automatic logic sel_strobe(logic [1:0] sel);
    case (sel)
      2'b00:   return r4096;
      2'b01:   return r64;
      2'b10:   return r1;
      default: return r60;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic tick, d;
    int   w;
    logic [7:0] n_cnt, n_load;
    tick = m_en && sel_strobe(m_sel) && (m_load != 0);
    d    = tick && (m_cnt == 1) && !val_wr;
    w    = exp_width(m_sel, m_load == 1);
    if (rst) begin
      m_en = 0; m_sel = 2'b11; m_load = 0; m_cnt = 0;
      m_flag = 0; m_pulse = 0; m_rem = 0;
    end else begin
      n_cnt = m_cnt; n_load = m_load;
      if (val_wr) begin n_load = val_wdata; n_cnt = val_wdata; end
      else if (tick) n_cnt = (m_cnt == 1) ? m_load : m_cnt - 8'd1;
      m_flag = (m_flag && (!flag_wr || flag_keep)) || d;
      if (!m_en) begin m_pulse = 0; m_rem = 0; end
      else if (d) begin m_pulse = 1; m_rem = w; end
      else if (m_pulse && ref_stb) begin
        if (m_rem <= 1) begin m_pulse = 0; m_rem = 0; end
        else m_rem = m_rem - 1;
      end
      if (ctl_wr) begin m_en = ctl_wdata[7]; m_sel = ctl_wdata[1:0]; end
      m_cnt = n_cnt; m_load = n_load;
    end
  endtask

  task automatic compare();
    chk(ctl_rdata == {m_en, 5'b0, m_sel}, "R1 ctl readback", ctl_rdata, {m_en, 5'b0, m_sel});
    chk(val_rdata == m_cnt, "R3 live count", val_rdata, m_cnt);
    chk(timer_flag == m_flag, "R5/R6 timer flag", timer_flag, m_flag);
    chk(irq_pulse == m_pulse, "R7 pulse level", irq_pulse, m_pulse);
  endtask

  task automatic cycle();
    if (auto_ref) ref_stb = (cyc_n % 3 == 0);
    model_step();
    if (irq_pulse && ref_stb) pw_seen++;
    @(posedge clk);
    @(negedge clk);
    cyc_n++;
    compare();
  endtask

  task automatic wr_ctl(bit en, logic [1:0] sel);
    ctl_wr = 1; ctl_wdata = {en, 5'b0, sel};
    cycle();
    ctl_wr = 0;
  endtask

  task automatic wr_val(logic [7:0] v);
    val_wr = 1; val_wdata = v;
    cycle();
    val_wr = 0;
  endtask

  task automatic clr_flag();
    flag_wr = 1; flag_keep = 0;
    cycle();
    flag_wr = 0;
  endtask

  task automatic set_rate(logic [1:0] sel, logic v);
    case (sel)
      2'b00: r4096 = v;
      2'b01: r64 = v;
      2'b10: r1 = v;
      default: r60 = v;
    endcase
  endtask

  task automatic fire(logic [1:0] sel);
    set_rate(sel, 1);
    cycle();
    set_rate(sel, 0);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cycle();
  endtask

  // R7: fire n strobes, then count reference strobes while pulse is high
  task automatic measure(logic [1:0] sel, logic [7:0] n, int exp_w);
    wr_ctl(0, sel);
    idle(2);
    clr_flag();
    wr_ctl(1, sel);
    wr_val(n);
    for (int i = 0; i < n; i++) fire(sel);
    chk(irq_pulse == 1, "R5 pulse starts at count end", irq_pulse, 1);
    chk(timer_flag == 1, "R5 flag with pulse", timer_flag, 1);
    chk(val_rdata == n, "R3 reload after end", val_rdata, n);
    pw_seen = 0;
    for (int i = 0; i < 1000 && irq_pulse; i++) cycle();
    chk(pw_seen == exp_w, "R7 pulse width in ref strobes", pw_seen, exp_w);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    idle(3);
    rst = 0;
    cycle();
    // R2 reset state
    chk(ctl_rdata == 8'h03, "R2 ctl reset", ctl_rdata, 8'h03);
    chk(val_rdata == 0, "R2 count reset", val_rdata, 0);
    chk(timer_flag == 0 && irq_pulse == 0, "R2 flag/pulse reset", {timer_flag, irq_pulse}, 0);

    // R1 readback ignores middle bits
    ctl_wr = 1; ctl_wdata = 8'hFD; cycle(); ctl_wr = 0;
    chk(ctl_rdata == 8'h81, "R1 middle bits read zero", ctl_rdata, 8'h81);

    // R4 zero start value halts
    wr_ctl(1, 2'b00);
    wr_val(0);
    r4096 = 1; idle(10); r4096 = 0;
    chk(val_rdata == 0 && timer_flag == 0, "R4 zero halts", val_rdata, 0);

    // R10 unselected strobes ignored
    wr_val(8'd7);
    r64 = 1; r1 = 1; r60 = 1; idle(6); r64 = 0; r1 = 0; r60 = 0;
    chk(val_rdata == 7, "R10 other rates ignored", val_rdata, 7);

    // R3 decrement, R8 write priority over strobe
    fire(2'b00); fire(2'b00);
    chk(val_rdata == 5, "R3 two decrements", val_rdata, 5);
    r4096 = 1; val_wr = 1; val_wdata = 8'd9; cycle(); r4096 = 0; val_wr = 0;
    chk(val_rdata == 9, "R8 write beats strobe", val_rdata, 9);

    // R7 every width case
    auto_ref = 1;
    measure(2'b00, 8'd1, 1);
    measure(2'b00, 8'd5, 2);
    measure(2'b01, 8'd1, 64);
    measure(2'b01, 8'd3, 128);
    measure(2'b10, 8'd2, 128);
    measure(2'b11, 8'd1, 128);

    // R6 keep and clear
    flag_wr = 1; flag_keep = 1; cycle(); flag_wr = 0;
    chk(timer_flag == 1, "R6 keep write", timer_flag, 1);
    clr_flag();
    chk(timer_flag == 0, "R6 clear write", timer_flag, 0);
    // R6 set wins over clear
    wr_ctl(1, 2'b00); wr_val(1);
    r4096 = 1; flag_wr = 1; flag_keep = 0; cycle(); r4096 = 0; flag_wr = 0;
    chk(timer_flag == 1, "R6 end beats clear", timer_flag, 1);

    // R9 disable mid-pulse, count frozen
    wr_ctl(1, 2'b01); wr_val(3);
    fire(2'b01); fire(2'b01); fire(2'b01);
    idle(4);
    chk(irq_pulse == 1, "R9 pulse running", irq_pulse, 1);
    wr_ctl(0, 2'b01);
    cycle();
    chk(irq_pulse == 0, "R9 pulse cut by disable", irq_pulse, 0);
    r64 = 1; idle(5); r64 = 0;
    chk(val_rdata == 3, "R9 count frozen", val_rdata, 3);

    // random mix
    for (int i = 0; i < 20000; i++) begin
      auto_ref = 0;
      ref_stb = ($urandom_range(0, 1) == 1);
      r4096 = ($urandom_range(0, 2) == 0);
      r64 = ($urandom_range(0, 4) == 0);
      r1 = ($urandom_range(0, 6) == 0);
      r60 = ($urandom_range(0, 8) == 0);
      ctl_wr = ($urandom_range(0, 150) == 0);
      ctl_wdata = {($urandom_range(0, 5) != 0), 5'($urandom), 2'($urandom)};
      val_wr = ($urandom_range(0, 200) == 0);
      val_wdata = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 4));
      flag_wr = ($urandom_range(0, 30) == 0);
      flag_keep = 1'($urandom);
      cycle();
    end
    ctl_wr = 0; val_wr = 0; flag_wr = 0;

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule